// File: doc/BRIEF.md
# Seconds Counter with Alarm Match

The block keeps a 32-bit count of elapsed seconds in the system clock domain. The count is paced by a slow external reference of 32.768 kHz. That reference is brought into the clock domain and its rising edges are detected. A prescaler then turns every 2^PRE_W edges into one increment of the seconds count.

Software drives the block through a small write port and a combinational read port. It can start and stop counting, overwrite the count, set an alarm value and mask the alarm interrupt. A sticky alarm flag is raised when the count steps onto the alarm value, and writing a one to the clear location drops it. A debug-halt input can freeze counting, depending on two control bits.

Top module: `sec_rtc`

## Requirements
- R1: After synchronous reset the count, the raw alarm flag and the interrupt output are all 0.
- R2: The first write that turns counting on after reset loads the count with 1, one cycle after the write. Any later off-to-on transition leaves the count unchanged.
- R3: While counting is allowed, the count rises by exactly one for every 2^PRE_W synchronized rising edges of the reference. With counting turned off, the count holds its value.
- R4: A write to the load location sets the count to the written data one cycle later and restarts the prescaler phase from zero.
- R5: Counting up from all ones wraps to 0 and then continues upward.
- R6: The raw alarm flag is set when an increment makes the count equal the alarm value. Once set, it stays set until it is cleared. While the count rests on the alarm value, the flag is not set again.
- R7: A write to the clear location with data bit 0 = 1 clears the raw alarm flag, and the same write with bit 0 = 0 has no effect. If an increment hits the alarm value in the same cycle as the clear, the flag stays set.
- R8: The interrupt output is high exactly when the raw alarm flag and the mask bit are both 1.
- R9: The debug-halt input freezes the count and the prescaler only when the stall bit is 1 and the continue bit is 0. With the continue bit set, or with neither bit set, counting proceeds during halt.
- R10: Register map by address:
  - Address 0 is control: bit 0 enable, bit 1 stall, bit 2 continue.
  - Address 1 is load.
  - Address 2 is the alarm value.
  - Address 3 is the mask, in bit 0.
  - Address 4 is the clear location.
  - Reads return: address 0 the control bits, address 1 the count, address 2 the alarm value, address 3 the mask, address 4 {irq, raw flag} in bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Asynchronous 32.768 kHz reference |
| dbg_halt | input | 1 | Debug halt request |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | CNT_W | Combinational read data |
| count | output | CNT_W | Current seconds count |
| match_raw | output | 1 | Sticky raw alarm flag |
| irq | output | 1 | Masked alarm interrupt |

## Verification
The assertions assume that the reference is much slower than the system clock, so that each synchronized level lasts several clock cycles. They also assume that at most one register write arrives per cycle. The stimulus toggles the reference every three clocks, which keeps it slow enough. It issues writes one at a time and spaces them by at least a cycle. It also runs the prescaler at four edges per second, so that many increments, a wrap and several alarm hits fit in a short run.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL  = 3'd0,
        REG_LOAD  = 3'd1,
        REG_MATCH = 3'd2,
        REG_MASK  = 3'd3,
        REG_CLR   = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic cont;
        logic stall;
        logic en;
    } ctrl_t;

    // counting is permitted unless a stall-only halt is in force
    function automatic logic count_allowed(ctrl_t c, logic halt);
        return c.en && !(halt && c.stall && !c.cont);
    endfunction

endpackage

// File: rtl/sec_rtc_refsync.sv
module sec_rtc_refsync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_in,
    output logic rise
);
    localparam int LAST = SYNC_STAGES;

    logic [LAST:0] chain;

    generate
        for (genvar i = 0; i <= LAST; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= ref_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign rise = chain[LAST-1] & ~chain[LAST];
endmodule

// File: rtl/sec_rtc_prescale.sv
module sec_rtc_prescale #(
    parameter int PRE_W = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic step,
    output logic tick
);
    localparam logic [PRE_W-1:0] PH_LAST = '1;

    logic [PRE_W-1:0] phase;

    assign tick = step && (phase == PH_LAST);

    always_ff @(posedge clk) begin
        if (rst || clear)
            phase <= '0;
        else if (step)
            phase <= phase + 1'b1;
    end
endmodule

// File: rtl/sec_rtc_regs.sv
module sec_rtc_regs
    import sec_rtc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output ctrl_t             ctl,
    output logic [CNT_W-1:0]  match_val,
    output logic              mask,
    output logic              load_stb,
    output logic              start_stb,
    output logic              clr_stb
);
    logic sel_ctrl, sel_match, sel_mask;

    always_comb begin
        sel_ctrl  = wr_en && (wr_addr == REG_CTRL);
        sel_match = wr_en && (wr_addr == REG_MATCH);
        sel_mask  = wr_en && (wr_addr == REG_MASK);
        load_stb  = wr_en && (wr_addr == REG_LOAD);
        clr_stb   = wr_en && (wr_addr == REG_CLR) && wr_data[0];
        start_stb = sel_ctrl && wr_data[0] && !ctl.en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl       <= '0;
            match_val <= '0;
            mask      <= 1'b0;
        end else begin
            if (sel_ctrl)  ctl       <= ctrl_t'(wr_data[2:0]);
            if (sel_match) match_val <= wr_data;
            if (sel_mask)  mask      <= wr_data[0];
        end
    end
endmodule

// File: rtl/sec_rtc_core.sv
module sec_rtc_core #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_stb,
    input  logic [CNT_W-1:0] load_val,
    input  logic             start_stb,
    input  logic             tick,
    input  logic [CNT_W-1:0] match_val,
    input  logic             clr_stb,
    output logic [CNT_W-1:0] count,
    output logic             status
);
    localparam logic [CNT_W-1:0] FIRST_VAL = CNT_W'(1);

    logic             first_pending;
    logic             do_preload;
    logic [CNT_W-1:0] next_up;
    logic             hit;

    always_comb begin
        do_preload = start_stb && first_pending;
        next_up    = count + 1'b1;
        hit        = tick && !load_stb && !do_preload && (next_up == match_val);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count         <= '0;
            first_pending <= 1'b1;
            status        <= 1'b0;
        end else begin
            if (load_stb) begin
                count         <= load_val;
                first_pending <= 1'b0;
            end else if (do_preload) begin
                count         <= FIRST_VAL;
                first_pending <= 1'b0;
            end else if (tick) begin
                count <= next_up;
            end
            status <= (status && !clr_stb) || hit;
        end
    end
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
    import sec_rtc_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int PRE_W       = 15,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_in,
    input  logic              dbg_halt,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic [CNT_W-1:0]  count,
    output logic              match_raw,
    output logic              irq
);
    ctrl_t            ctl;
    logic [CNT_W-1:0] match_val;
    logic             mask;
    logic             load_stb, start_stb, clr_stb;
    logic             ref_rise, run, tick;

    sec_rtc_refsync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .ref_in(ref_in), .rise(ref_rise)
    );

    sec_rtc_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ctl(ctl), .match_val(match_val), .mask(mask),
        .load_stb(load_stb), .start_stb(start_stb), .clr_stb(clr_stb)
    );

    assign run = count_allowed(ctl, dbg_halt);

    sec_rtc_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst(rst), .clear(load_stb), .step(ref_rise && run), .tick(tick)
    );

    sec_rtc_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst(rst), .load_stb(load_stb), .load_val(wr_data),
        .start_stb(start_stb), .tick(tick), .match_val(match_val),
        .clr_stb(clr_stb), .count(count), .status(match_raw)
    );

    assign irq = match_raw && mask;

    always_comb begin
        case (rd_addr)
            REG_CTRL:  rd_data = {{(CNT_W-3){1'b0}}, ctl};
            REG_LOAD:  rd_data = count;
            REG_MATCH: rd_data = match_val;
            REG_MASK:  rd_data = {{(CNT_W-1){1'b0}}, mask};
            REG_CLR:   rd_data = {{(CNT_W-2){1'b0}}, irq, match_raw};
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/sec_rtc_chk.sv
module sec_rtc_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [2:0]       wr_addr,
    input logic [CNT_W-1:0] wr_data,
    input logic             dbg_halt,
    input logic             ctl_en,
    input logic             ctl_stall,
    input logic             ctl_cont,
    input logic [CNT_W-1:0] count,
    input logic             match_raw,
    input logic             irq
);
    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R3
    hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl_en && !wr_en) |=> $stable(count));

    // R3
    step_of_one_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(wr_en) && (count != $past(count)))
            |-> (count == CNT_W'($past(count) + 1'b1)));

    // R9
    stall_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_en && ctl_stall && !ctl_cont && dbg_halt && !wr_en) |=> $stable(count));

    // R4
    load_value_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 3'd1) |=> (count == $past(wr_data)));

    // R6
    status_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (match_raw && !(wr_en && wr_addr == 3'd4 && wr_data[0])) |=> match_raw);

    // R8
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> match_raw);
endmodule

bind sec_rtc sec_rtc_chk #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dbg_halt(dbg_halt), .ctl_en(ctl.en), .ctl_stall(ctl.stall), .ctl_cont(ctl.cont),
    .count(count), .match_raw(match_raw), .irq(irq)
);

// File: tb/sec_rtc_tb_top.sv
module sec_rtc_tb_top;
    localparam int PRE_W = 2;
    localparam int PRE_N = 1 << PRE_W;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_in = 1'b0;
    logic        dbg_halt = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data, count;
    logic        match_raw, irq;

    int checks = 0;
    int failures = 0;
    bit cmp_on = 1'b0;

    always #10 clk = ~clk;

    sec_rtc #(.PRE_W(PRE_W)) dut_i (
        .clk(clk), .rst(rst), .ref_in(ref_in), .dbg_halt(dbg_halt),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .count(count), .match_raw(match_raw), .irq(irq)
    );

    // reference toggling every three clocks
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            ref_in = ~ref_in;
        end
    end

    // behavioural model
    bit          h0, h1, h2;
    int          ph;
    logic [31:0] cnt_m, match_m;
    bit          st_m, first_m, en_m, stall_m, cont_m, mask_m;

    always @(posedge clk) begin
        bit rise, allow, tk, ld, start, clr, hit;
        if (rst) begin
            h0 = 0; h1 = 0; h2 = 0; ph = 0; cnt_m = 0; match_m = 0;
            st_m = 0; first_m = 1; en_m = 0; stall_m = 0; cont_m = 0; mask_m = 0;
        end else begin
            rise  = h1 && !h2;
            allow = en_m && !(dbg_halt && stall_m && !cont_m);
            tk    = rise && allow && (ph == PRE_N - 1);
            ld    = wr_en && wr_addr == 3'd1;
            start = wr_en && wr_addr == 3'd0 && wr_data[0] && !en_m;
            clr   = wr_en && wr_addr == 3'd4 && wr_data[0];
            hit   = 0;
            if (ld) begin
                cnt_m = wr_data; first_m = 0;
            end else if (start && first_m) begin
                cnt_m = 1; first_m = 0;
            end else if (tk) begin
                cnt_m = cnt_m + 1;
                hit = (cnt_m == match_m);
            end
            st_m = (st_m && !clr) || hit;
            if (ld) ph = 0;
            else if (rise && allow) ph = (ph + 1) % PRE_N;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: begin en_m = wr_data[0]; stall_m = wr_data[1]; cont_m = wr_data[2]; end
                    3'd2: match_m = wr_data;
                    3'd3: mask_m = wr_data[0];
                    default: ;
                endcase
            end
            h2 = h1; h1 = h0; h0 = ref_in;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_on && !rst) begin
            chk("R3 count vs model", count, cnt_m);
            chk("R6 flag vs model", {31'd0, match_raw}, {31'd0, st_m});
            chk("R8 irq vs model", {31'd0, irq}, {31'd0, st_m && mask_m});
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_count(input logic [31:0] v, input string req);
        int n = 0;
        while (count !== v && n < 1000) begin
            @(negedge clk);
            n++;
        end
        chk(req, count, v);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] held;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        cmp_on = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 count", count, 0);
        chk("R1 flag", {31'd0, match_raw}, 0);
        chk("R1 irq", {31'd0, irq}, 0);

        wr(3'd2, 32'd3);
        wr(3'd3, 32'd0);
        wr(3'd0, 32'd1);
        // R2 first start loads one
        chk("R2 preload", count, 32'd1);
        wait_count(32'd2, "R3 advance to 2");
        wait_count(32'd3, "R3 advance to 3");
        @(negedge clk);
        // R6 / R8 masked
        chk("R6 flag on hit", {31'd0, match_raw}, 1);
        chk("R8 masked irq", {31'd0, irq}, 0);
        wr(3'd3, 32'd1);
        chk("R8 unmasked irq", {31'd0, irq}, 1);
        // R10 readback
        rd_addr = 3'd4; #1;
        chk("R10 read status", rd_data, 32'd3);
        rd_addr = 3'd2; #1;
        chk("R10 read match", rd_data, 32'd3);
        // R7
        wr(3'd4, 32'd0);
        chk("R7 zero write ignored", {31'd0, match_raw}, 1);
        wr(3'd4, 32'd1);
        chk("R7 clear", {31'd0, match_raw}, 0);
        chk("R8 irq drops", {31'd0, irq}, 0);

        // R3 disabled hold, R2 no second preload
        wr(3'd0, 32'd0);
        held = count;
        repeat (100) @(negedge clk);
        chk("R3 hold when off", count, held);
        wr(3'd0, 32'd1);
        chk("R2 no reload on restart", count, held);

        // R4 / R5
        wr(3'd1, 32'hFFFF_FFFE);
        chk("R4 load", count, 32'hFFFF_FFFE);
        wait_count(32'hFFFF_FFFF, "R5 reach all ones");
        wait_count(32'h0, "R5 wrap to zero");
        wait_count(32'h1, "R5 continue after wrap");

        // R9 halt modes
        dbg_halt = 1'b1;
        wr(3'd0, 32'd3);
        held = count;
        repeat (120) @(negedge clk);
        chk("R9 stall freezes", count, held);
        wr(3'd0, 32'd5);
        wait_count(held + 1, "R9 continue runs");
        wr(3'd0, 32'd7);
        wait_count(held + 2, "R9 both set runs");
        wr(3'd0, 32'd1);
        wait_count(held + 3, "R9 neither set runs");
        dbg_halt = 1'b0;

        // R6 single raise while resting on match
        wr(3'd1, 32'd10);
        wr(3'd2, 32'd11);
        wait_count(32'd11, "R6 reach match");
        @(negedge clk);
        chk("R6 flag on second hit", {31'd0, match_raw}, 1);
        wr(3'd0, 32'd0);
        wr(3'd4, 32'd1);
        repeat (60) @(negedge clk);
        chk("R6 no re-raise at rest", {31'd0, match_raw}, 0);
        chk("R6 count rests on match", count, 32'd11);
        rd_addr = 3'd1; #1;
        chk("R10 read count", rd_data, 32'd11);

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule